// File: doc/BRIEF.md
# Misaligned Access Cycle Splitter

The splitter sits between a processor's load/store path and a 32-bit bus sequencer whose addresses name whole doublewords and whose four byte lanes are qualified by active-low enables. The processor presents one request: a byte address, an operand size, a direction flag and, for stores, the operand. The splitter turns it into one or two bus transactions. For each transaction it produces the doubleword address, the lane enables and the store bytes placed on their lanes.

When an operand runs past the end of its doubleword, the splitter issues two transactions. The part that lies in the higher doubleword goes out first and the part in the starting doubleword goes out second. For loads, the lanes returned by both transactions are merged. The operand is handed back right-justified, but only once the second transaction has completed.

Each transaction uses a level request held until the sequencer signals completion for one cycle. A new processor request is taken only while the splitter is idle.

Top module: `misalign_splitter`

## Requirements
- R1: Size code 2'b00 is one byte, 2'b01 is two bytes, and 2'b10 and 2'b11 are four bytes.
- R2: Byte enables are active low: bit L of `bus_be_n` is 0 exactly when lane L carries an operand byte. Operand byte k travels on lane (address + k) mod 4, and no transaction has all enables high.
- R3: On a store, operand byte k is driven on its lane of `bus_wdata`, and lanes whose enable is high carry 8'h00.
- R4: An operand that stays inside one doubleword needs one transaction, at the address bits [31:2] of the request.
- R5: An operand that crosses a doubleword boundary needs two transactions. The first goes to the next doubleword and enables its low lanes. The second goes to the starting doubleword and enables its high lanes, including lane 3.
- R6: The next-doubleword address wraps: a crossing request in doubleword 30'h3FFFFFFF sends its first transaction to doubleword 0.
- R7: `bus_req` rises in the cycle after acceptance. It stays high with address, enables and store data unchanged until `bus_done` is sampled high. The second transaction of a split request appears in the cycle right after the first completes.
- R8: A load returns its operand right-justified in `rsp_rdata`, with bits above the operand size at zero. A split load combines the bytes of both transactions.
- R9: `rsp_valid` is a single-cycle pulse in the cycle after the last `bus_done`. In that cycle `busy` is already low.
- R10: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the cycle of the last `bus_done`, and `req_valid` asserted while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 32 | Store operand, right-justified |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Request finished, load data valid |
| rsp_rdata | output | 32 | Load operand, right-justified |
| bus_req | output | 1 | Transaction request to the sequencer |
| bus_addr | output | 30 | Doubleword address |
| bus_be_n | output | 4 | Active-low lane enables |
| bus_write | output | 1 | Transaction direction |
| bus_wdata | output | 32 | Store bytes on their lanes |
| bus_done | input | 1 | Transaction complete, read lanes valid |
| bus_rdata | input | 32 | Read lanes returned by the sequencer |

## Verification
The first transaction is due one cycle after the accepting edge. Each further transaction appears one cycle after the `bus_done` of the one before it. `rsp_valid`, `rsp_rdata` and the drop of `busy` all arrive one cycle after the last `bus_done`. The bench drives inputs on the falling edge and builds a queue of expected transactions from the byte loop over the operand. At every falling edge it compares the held transaction, `busy` and `rsp_valid`, so each result is checked exactly in the cycle it is due, under wait-state counts that vary from request to request.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

   localparam int OP_W     = 32;
   localparam int OP_BYTES = OP_W / 8;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2
   } phase_e;

   // operand length in bytes for a size code
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'b00:   size_bytes = 3'd1;
         2'b01:   size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/msplit_plan.sv
module msplit_plan
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [1:0]                        size,
   input  logic [OP_W-1:0]                   wdata,
   output logic                              split,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0] dw_lo,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0] dw_hi,
   output logic [DATA_W/8-1:0]               be_n_lo,
   output logic [DATA_W/8-1:0]               be_n_hi,
   output logic [DATA_W-1:0]                 data_lo,
   output logic [DATA_W-1:0]                 data_hi
);
   localparam int LANES  = DATA_W / 8;
   localparam int OFS_W  = $clog2(LANES);
   localparam int MASK_W = 2 * LANES;

   logic [OFS_W-1:0]    ofs;
   logic [2:0]          nbytes;
   logic [MASK_W-1:0]   base;
   logic [MASK_W-1:0]   span;
   logic [2*DATA_W-1:0] lanes;

   assign ofs    = addr[OFS_W-1:0];
   assign nbytes = size_bytes(size);
   assign dw_lo  = addr[ADDR_W-1:OFS_W];
   assign dw_hi  = dw_lo + 1'b1;

   always_comb begin
      base = '0;
      for (int i = 0; i < OP_BYTES; i++) begin
         if (i < int'(nbytes)) base[i] = 1'b1;
      end
      span = base << ofs;
   end

   assign split   = |span[MASK_W-1:LANES];
   assign be_n_lo = ~span[LANES-1:0];
   assign be_n_hi = ~span[MASK_W-1:LANES];

   // one byte selector per lane across both doublewords
   for (genvar l = 0; l < MASK_W; l++) begin : g_lane
      logic [7:0] lane_byte;
      always_comb begin
         lane_byte = 8'h00;
         if (span[l]) begin
            for (int k = 0; k < OP_BYTES; k++) begin
               if (int'(ofs) + k == l) lane_byte = wdata[8*k +: 8];
            end
         end
      end
      assign lanes[8*l +: 8] = lane_byte;
   end

   assign data_lo = lanes[DATA_W-1:0];
   assign data_hi = lanes[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/msplit_ctrl.sv
module msplit_ctrl
   import msplit_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   split,
   input  logic   bus_done,
   output phase_e phase,
   output logic   accept,
   output logic   cap_hi,
   output logic   finish,
   output logic   busy,
   output logic   rsp_valid
);
   phase_e phase_q, phase_d;

   assign phase  = phase_q;
   assign busy   = (phase_q != PH_IDLE);
   assign accept = req_valid && (phase_q == PH_IDLE);
   assign cap_hi = bus_done && split && (phase_q == PH_FIRST);
   assign finish = bus_done && (((phase_q == PH_FIRST) && !split) ||
                                (phase_q == PH_SECOND));

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_IDLE:   if (accept) phase_d = PH_FIRST;
         PH_FIRST:  if (bus_done) phase_d = split ? PH_SECOND : PH_IDLE;
         PH_SECOND: if (bus_done) phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         rsp_valid <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         rsp_valid <= finish;
      end
   end

endmodule

// File: rtl/msplit_merge.sv
module msplit_merge
   import msplit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap_hi,
   input  logic                        finish,
   input  logic                        load,
   input  logic                        split,
   input  logic [$clog2(DATA_W/8)-1:0] ofs,
   input  logic [1:0]                  size,
   input  logic [DATA_W-1:0]           rdata,
   output logic [OP_W-1:0]             operand
);
   logic [DATA_W-1:0]   hi_buf;
   logic [2*DATA_W-1:0] joined;
   logic [OP_W-1:0]     picked;
   logic [2:0]          nbytes;

   assign nbytes = size_bytes(size);
   assign joined = {split ? hi_buf : '0, rdata};

   for (genvar k = 0; k < OP_BYTES; k++) begin : g_byte
      logic [7:0] op_byte;
      always_comb begin
         op_byte = 8'h00;
         if (k < int'(nbytes)) op_byte = joined[8*(int'(ofs) + k) +: 8];
      end
      assign picked[8*k +: 8] = op_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_buf  <= '0;
         operand <= '0;
      end else begin
         if (cap_hi) hi_buf <= rdata;
         if (finish && load) operand <= picked;
      end
   end

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                req_valid,
   input  logic [ADDR_W-1:0]                   req_addr,
   input  logic [1:0]                          req_size,
   input  logic                                req_write,
   input  logic [OP_W-1:0]                     req_wdata,
   output logic                                busy,
   output logic                                rsp_valid,
   output logic [OP_W-1:0]                     rsp_rdata,
   output logic                                bus_req,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  bus_addr,
   output logic [DATA_W/8-1:0]                 bus_be_n,
   output logic                                bus_write,
   output logic [DATA_W-1:0]                   bus_wdata,
   input  logic                                bus_done,
   input  logic [DATA_W-1:0]                   bus_rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = $clog2(LANES);
   localparam int DWA_W = ADDR_W - OFS_W;

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
      $error("misalign_splitter: DATA_W must be 32 or 64");
   end
   if (ADDR_W <= OFS_W + 1) begin : g_bad_addr_w
      $error("misalign_splitter: ADDR_W too small for DATA_W");
   end

   logic [ADDR_W-1:0] lat_addr;
   logic [1:0]        lat_size;
   logic              lat_write;
   logic [OP_W-1:0]   lat_wdata;

   phase_e            phase;
   logic              accept, cap_hi, finish, split, sel_hi;
   logic [DWA_W-1:0]  dw_lo, dw_hi;
   logic [LANES-1:0]  be_n_lo, be_n_hi;
   logic [DATA_W-1:0] data_lo, data_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr  <= '0;
         lat_size  <= '0;
         lat_write <= 1'b0;
         lat_wdata <= '0;
      end else if (accept) begin
         lat_addr  <= req_addr;
         lat_size  <= req_size;
         lat_write <= req_write;
         lat_wdata <= req_wdata;
      end
   end

   msplit_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
      .addr    (lat_addr),
      .size    (lat_size),
      .wdata   (lat_wdata),
      .split   (split),
      .dw_lo   (dw_lo),
      .dw_hi   (dw_hi),
      .be_n_lo (be_n_lo),
      .be_n_hi (be_n_hi),
      .data_lo (data_lo),
      .data_hi (data_hi)
   );

   msplit_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .split     (split),
      .bus_done  (bus_done),
      .phase     (phase),
      .accept    (accept),
      .cap_hi    (cap_hi),
      .finish    (finish),
      .busy      (busy),
      .rsp_valid (rsp_valid)
   );

   msplit_merge #(.DATA_W(DATA_W)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_hi  (cap_hi),
      .finish  (finish),
      .load    (!lat_write),
      .split   (split),
      .ofs     (lat_addr[OFS_W-1:0]),
      .size    (lat_size),
      .rdata   (bus_rdata),
      .operand (rsp_rdata)
   );

   // higher doubleword first whenever the operand crosses
   assign sel_hi    = (phase == PH_FIRST) && split;
   assign bus_req   = busy;
   assign bus_addr  = sel_hi ? dw_hi   : dw_lo;
   assign bus_be_n  = sel_hi ? be_n_hi : be_n_lo;
   assign bus_wdata = sel_hi ? data_hi : data_lo;
   assign bus_write = lat_write;

endmodule

// File: rtl/msplit_chk.sv
module msplit_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               req_valid,
   input logic                               busy,
   input logic                               rsp_valid,
   input logic                               bus_req,
   input logic [ADDR_W-$clog2(DATA_W/8)-1:0] bus_addr,
   input logic [DATA_W/8-1:0]                bus_be_n,
   input logic [DATA_W-1:0]                  bus_wdata,
   input logic                               bus_done
);
   localparam int LANES = DATA_W / 8;

   // R2: a transaction always enables at least one lane
   a_r2_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_be_n != {LANES{1'b1}}));

   // R7: transaction fields held while waiting
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_done) |=>
         (bus_req && $stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wdata)));

   // R5: a follow-on transaction targets the doubleword below the first
   a_r5_lower_second: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_done) |=> (!bus_req || (bus_addr == $past(bus_addr) - 1'b1)));

   // R5: the second part always includes the top lane
   a_r5_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_done) |=> (!bus_req || !bus_be_n[LANES-1]));

   // R9: completion pulse is one cycle and comes with busy low
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy);

   // R10: an idle request is taken
   a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

endmodule

bind misalign_splitter msplit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_msplit_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .rsp_valid (rsp_valid),
   .bus_req   (bus_req),
   .bus_addr  (bus_addr),
   .bus_be_n  (bus_be_n),
   .bus_wdata (bus_wdata),
   .bus_done  (bus_done)
);

// File: tb/test_misalign_splitter.sv
`timescale 1ns/1ps
module test_misalign_splitter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        busy, rsp_valid, bus_req, bus_write;
   logic [31:0] rsp_rdata, bus_wdata;
   logic [29:0] bus_addr;
   logic [3:0]  bus_be_n;
   logic        bus_done = 1'b0;
   logic [31:0] bus_rdata = '0;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   misalign_splitter i_misalign_splitter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
      .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_done(bus_done),
      .bus_rdata(bus_rdata)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [29:0] dw);
      return ({dw, 2'b01} * 32'h9E3779B1) ^ 32'h5A5AC3C3;
   endfunction

   // expected transactions of the current request
   logic [29:0] q_addr[$];
   logic [3:0]  q_be[$];
   logic [31:0] q_dat[$];

   task automatic build(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd_exp);
      int n;
      logic [29:0] first_dw, last_dw, dw;
      logic [31:0] b;
      logic [3:0]  be;
      logic [31:0] dat;
      n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      q_addr.delete(); q_be.delete(); q_dat.delete();
      first_dw = a[31:2];
      b = a + 32'(n - 1);
      last_dw = b[31:2];
      rd_exp = '0;
      for (int g = 0; g < 2; g++) begin
         if (g == 0 && last_dw == first_dw) continue;
         dw = (g == 0) ? last_dw : first_dw;
         be = 4'hF;
         dat = '0;
         for (int i = 0; i < n; i++) begin
            b = a + 32'(i);
            if (b[31:2] == dw) begin
               be[b[1:0]] = 1'b0;
               dat[8*b[1:0] +: 8] = wd[8*i +: 8];
            end
         end
         q_addr.push_back(dw); q_be.push_back(be); q_dat.push_back(dat);
      end
      for (int i = 0; i < n; i++) begin
         b = a + 32'(i);
         rd_exp[8*i +: 8] = mem_word(b[31:2])[8*b[1:0] +: 8];
      end
   endtask

   task automatic run_op(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input int w0, input int w1, input bit poke);
      logic [31:0] rd_exp;
      int waits;
      build(a, sz, wd, rd_exp);
      @(negedge clk);
      check("R10 idle before request", {63'd0, busy}, 64'd0);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < q_addr.size(); t++) begin
         waits = (t == 0) ? w0 : w1;
         for (int c = 0; c <= waits; c++) begin
            req_valid = 1'b0;
            check("R7 bus_req held", {63'd0, bus_req}, 64'd1);
            check("R10 busy during transfer", {63'd0, busy}, 64'd1);
            check("R9 no early response", {63'd0, rsp_valid}, 64'd0);
            check((q_addr.size() > 1) ? "R5 split address" : "R4 single address",
                  {34'd0, bus_addr}, {34'd0, q_addr[t]});
            check("R2 lane enables", {60'd0, bus_be_n}, {60'd0, q_be[t]});
            check("R7 direction", {63'd0, bus_write}, {63'd0, wr});
            if (wr) check("R3 store lanes", {32'd0, bus_wdata}, {32'd0, q_dat[t]});
            if (poke && t == 0 && c == 0 && waits > 0) begin
               req_valid = 1'b1; req_addr = a ^ 32'h0000_0F01; req_size = 2'b10;
               req_write = ~wr;
            end
            if (c == waits) begin
               bus_done = 1'b1; bus_rdata = mem_word(q_addr[t]);
            end else begin
               bus_done = 1'b0; bus_rdata = 32'hDEAD_0000 | 32'(c);
            end
            @(negedge clk);
         end
         bus_done = 1'b0;
         bus_rdata = 32'h0BAD_F00D;
      end
      req_valid = 1'b0;
      check("R9 response pulse", {63'd0, rsp_valid}, 64'd1);
      check("R9 busy low at response", {63'd0, busy}, 64'd0);
      check("R10 no extra transaction", {63'd0, bus_req}, 64'd0);
      if (!wr) check("R8 load operand", {32'd0, rsp_rdata}, {32'd0, rd_exp});
      @(negedge clk);
      check("R9 pulse ends", {63'd0, rsp_valid}, 64'd0);
      check("R10 ignored request started nothing", {63'd0, bus_req}, 64'd0);
   endtask

   initial begin
      #1;
      check("R10 reset busy", {63'd0, busy}, 64'd0);
      check("R7 reset bus_req", {63'd0, bus_req}, 64'd0);
      check("R9 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R8 reset operand", {32'd0, rsp_rdata}, 64'd0);
      // R1 R4 R5: every size at every offset, both directions
      for (int wr = 0; wr < 2; wr++) begin
         for (int sz = 0; sz < 3; sz++) begin
            for (int o = 0; o < 4; o++) begin
               run_op(wr[0], 32'h1234_5670 + 32'(o) + 32'(sz * 64), sz[1:0],
                      32'hA1B2_C3D4 ^ 32'(o * 32'h0101_0101), (o + sz) % 3, (o * 2 + wr) % 3, 1'b0);
            end
         end
      end
      // R1: code 2'b11 behaves as four bytes
      run_op(1'b0, 32'h0000_2002, 2'b11, 32'h0, 1, 0, 1'b0);
      run_op(1'b1, 32'h0000_3003, 2'b11, 32'h8899_AABB, 0, 2, 1'b0);
      // R6: wrap past the top doubleword
      run_op(1'b0, 32'hFFFF_FFFE, 2'b10, 32'h0, 0, 1, 1'b0);
      run_op(1'b1, 32'hFFFF_FFFF, 2'b01, 32'h0000_5A6B, 2, 0, 1'b0);
      // R10: request while busy is ignored
      run_op(1'b0, 32'h0000_4001, 2'b10, 32'h0, 2, 1, 1'b1);
      run_op(1'b1, 32'h0000_5002, 2'b00, 32'h0000_00EE, 3, 0, 1'b1);
      // R7: long wait states
      run_op(1'b0, 32'h0000_6003, 2'b01, 32'h0, 7, 5, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule